// File: doc/BRIEF.md
# Multi-Ring XOR Sampling Combiner

This block turns a set of free-running oscillator signals into a raw random bit stream. On each edge of a sampling clock every oscillator level is caught in its own flip-flop. The registered levels are folded into one parity bit, and that bit is registered a second time. The result is one raw bit per sampling cycle, with no whitening or compression applied. The bits are gathered into 16-bit words for a parallel host port, and a one-cycle strobe marks each completed word.

The sampling clock is either an external reference (nominally 32 MHz in a real system) or a spare oscillator divided by eight. A parameter fixes the source, or leaves the choice to a select pin. The oscillators themselves, any post-processing and any statistical evaluation sit outside the block.

Top module: `ring_xor_sampler`

## Requirements
- R1: Each bit of `ring_in` is captured in its own flip-flop on the rising edge of the sampling clock before any combining logic.
- R2: Once `raw_valid` is high, `raw_bit` after sampling edge k equals the parity of all `ring_in` levels at edge k-1. This is one edge later than a parity-then-sample design. For a square wave that starts low, first rises at time d and has half period h, the level at time t is 1 when t >= d and floor((t-d)/h) is even, and 0 otherwise.
- R3: With `NUM_RINGS` = 1, `raw_bit` is the single ring level delayed by two sampling edges.
- R4: A synchronous active-high `rst` clears the ring flops, `raw_bit`, `word_out`, `word_valid` and the bit count. `raw_valid` stays low for the first two sampling edges after release and is high from the second edge on.
- R5: Valid raw bits enter the word MSB first, so the oldest bit ends up in bit 15 and the newest in bit 0. `word_valid` is high for exactly one sampling cycle when the 16th bit lands. After reset release this first happens after edge 18, and then every 16 edges.
- R6: `word_out` keeps its value between completed words.
- R7: When the internal source is selected (`clk_sel` = 1 with `CLK_MODE` = 2), `samp_clk` is the MSB of a 3-bit counter clocked by `aux_ring`. It is therefore high for four `aux_ring` periods and low for four. With `clk_sel` = 0, `samp_clk` follows `ref_clk`.
- R8: The divider clears on the first `aux_ring` rising edge that sees `rst` newly high, then runs freely, so the first following `samp_clk` rise comes four `aux_ring` periods after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | External sampling reference |
| aux_ring | input | 1 | Spare oscillator feeding the divide-by-8 |
| clk_sel | input | 1 | 1 selects the divided oscillator when CLK_MODE = 2 |
| rst | input | 1 | Synchronous active-high reset, sampling domain |
| ring_in | input | NUM_RINGS | Asynchronous oscillator levels |
| samp_clk | output | 1 | Sampling clock in use |
| raw_bit | output | 1 | Registered parity bit |
| raw_valid | output | 1 | Raw pipeline has filled |
| word_out | output | WORD_W | Last completed word, oldest bit in MSB |
| word_valid | output | 1 | One-cycle strobe on word completion |

## Verification
The bench builds two copies side by side: one with eight rings and one with a single ring. Both use `CLK_MODE` = 2, so one run covers the external and the divided clock through `clk_sel`. The eight-ring copy brings within reach mixes of free-running and pinned rings that give constant-0, constant-1 and varying parity. The single-ring copy exposes the plain two-edge delay without any parity folding. The select pin also lets the bench time the divided clock's duty cycle and the divider restart against the known `aux_ring` period.

// File: rtl/ring_xor_sampler.sv
`timescale 1ps/1ps
module ring_xor_sampler #(
  parameter int NUM_RINGS = 8,
  parameter int WORD_W    = 16,
  parameter int DIV_LOG2  = 3,
  parameter int CLK_MODE  = 2
) (
  input  logic                 ref_clk,
  input  logic                 aux_ring,
  input  logic                 clk_sel,
  input  logic                 rst,
  input  logic [NUM_RINGS-1:0] ring_in,
  output logic                 samp_clk,
  output logic                 raw_bit,
  output logic                 raw_valid,
  output logic [WORD_W-1:0]    word_out,
  output logic                 word_valid
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  generate
    if (CLK_MODE == 0) begin : g_ext
      assign samp_clk = ref_clk;
    end else begin : g_div
      logic [DIV_LOG2-1:0] div_q;
      logic                rst_aux_q;
      always_ff @(posedge aux_ring) begin
        rst_aux_q <= rst;
        if (rst && !rst_aux_q) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end
      if (CLK_MODE == 1) begin : g_int
        assign samp_clk = div_q[DIV_LOG2-1];
      end else begin : g_mux
        assign samp_clk = clk_sel ? div_q[DIV_LOG2-1] : ref_clk;
      end
    end
  endgenerate

  logic [NUM_RINGS-1:0] ring_q;
  logic                 raw_q;
  logic [1:0]           fill_q;
  logic [WORD_W-1:0]    shift_q;
  logic [CNT_W-1:0]     bit_cnt_q;
  logic [WORD_W-1:0]    word_q;
  logic                 word_v_q;
  logic [WORD_W-1:0]    shift_nxt;

  assign shift_nxt = {shift_q[WORD_W-2:0], raw_q};

  always_ff @(posedge samp_clk) begin
    if (rst) begin
      ring_q    <= '0;
      raw_q     <= 1'b0;
      fill_q    <= 2'd0;
      shift_q   <= '0;
      bit_cnt_q <= '0;
      word_q    <= '0;
      word_v_q  <= 1'b0;
    end else begin
      ring_q   <= ring_in;
      raw_q    <= ^ring_q;
      word_v_q <= 1'b0;
      if (!fill_q[1]) fill_q <= fill_q + 2'd1;
      if (fill_q[1]) begin
        shift_q   <= shift_nxt;
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST_BIT) begin
          word_q    <= shift_nxt;
          word_v_q  <= 1'b1;
          bit_cnt_q <= '0;
        end
      end
    end
  end

  assign raw_bit    = raw_q;
  assign raw_valid  = fill_q[1];
  assign word_out   = word_q;
  assign word_valid = word_v_q;

endmodule

// File: rtl/ring_xor_sampler_chk.sv
`timescale 1ps/1ps
module ring_xor_sampler_chk #(
  parameter int NUM_RINGS = 8,
  parameter int WORD_W    = 16
) (
  input logic                 samp_clk,
  input logic                 rst,
  input logic [NUM_RINGS-1:0] ring_in,
  input logic                 raw_bit,
  input logic                 raw_valid,
  input logic [WORD_W-1:0]    word_out,
  input logic                 word_valid
);

  // R2
  parity_lag_chk: assert property (@(posedge samp_clk) disable iff (rst)
    raw_valid |-> raw_bit == $past(^ring_in, 2));

  // R4
  fill_wait_chk: assert property (@(posedge samp_clk) disable iff (rst)
    $past(rst) |-> !raw_valid);

  // R4
  reset_clear_chk: assert property (@(posedge samp_clk) disable iff (rst)
    $past(rst) |-> (word_out == '0 && !word_valid && !raw_bit));

  // R5
  strobe_single_chk: assert property (@(posedge samp_clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R5
  newest_lsb_chk: assert property (@(posedge samp_clk) disable iff (rst)
    word_valid |-> word_out[0] == $past(raw_bit));

  // R6
  word_hold_chk: assert property (@(posedge samp_clk) disable iff (rst)
    (!word_valid && !$past(rst)) |-> $stable(word_out));

endmodule

bind ring_xor_sampler ring_xor_sampler_chk #(.NUM_RINGS(NUM_RINGS), .WORD_W(WORD_W)) chk_i (
  .samp_clk(samp_clk), .rst(rst), .ring_in(ring_in), .raw_bit(raw_bit),
  .raw_valid(raw_valid), .word_out(word_out), .word_valid(word_valid)
);

// File: tb/ring_xor_sampler_tb_top.sv
`timescale 1ps/1ps
module ring_xor_sampler_tb_top;

  localparam int NR = 8;
  localparam int RUN_CYC = 40;
  localparam int NVEC = 6;
  // {clk_sel, force_en[7:0], force_val[7:0]}
  localparam logic [16:0] VECS [NVEC] = '{
    {1'b0, 8'h00, 8'h00},
    {1'b0, 8'hFF, 8'hA5},
    {1'b0, 8'hFE, 8'h80},
    {1'b1, 8'h00, 8'h00},
    {1'b1, 8'h0F, 8'h07},
    {1'b0, 8'hFF, 8'h01}
  };

  logic ref_clk = 1'b0;
  logic aux_ring = 1'b0;
  logic clk_sel = 1'b0;
  logic rst = 1'b0;
  logic [NR-1:0] osc;
  logic [NR-1:0] fen = '0;
  logic [NR-1:0] fval = '0;
  logic [NR-1:0] ring_in;

  logic samp_clk, raw_bit, raw_valid, word_valid;
  logic [15:0] word_out;
  logic s1_clk, s1_bit, s1_valid, s1_wvalid;
  logic [15:0] s1_word;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  assign ring_in = (osc & ~fen) | (fval & fen);

  always #4000 ref_clk = ~ref_clk;

  initial begin
    #500;
    forever begin
      aux_ring = 1'b1; #1000;
      aux_ring = 1'b0; #1000;
    end
  end

  for (genvar g = 0; g < NR; g++) begin : g_osc
    initial begin
      osc[g] = 1'b0;
      #(1001 + 346 * g);
      forever begin
        osc[g] = ~osc[g];
        #(3100 + 214 * g);
      end
    end
  end

  ring_xor_sampler #(.NUM_RINGS(NR)) dut_i (
    .ref_clk(ref_clk), .aux_ring(aux_ring), .clk_sel(clk_sel), .rst(rst),
    .ring_in(ring_in), .samp_clk(samp_clk), .raw_bit(raw_bit),
    .raw_valid(raw_valid), .word_out(word_out), .word_valid(word_valid));

  ring_xor_sampler #(.NUM_RINGS(1)) dut1_i (
    .ref_clk(ref_clk), .aux_ring(aux_ring), .clk_sel(clk_sel), .rst(rst),
    .ring_in(ring_in[0]), .samp_clk(s1_clk), .raw_bit(s1_bit),
    .raw_valid(s1_valid), .word_out(s1_word), .word_valid(s1_wvalid));

  function automatic logic lvl(int j, longint t);
    longint d = 1001 + 346 * j;
    longint h = 3100 + 214 * j;
    if (fen[j]) return fval[j];
    if (t < d) return 1'b0;
    return (((t - d) / h) % 2) == 0;
  endfunction

  function automatic logic par_all(longint t);
    logic p = 1'b0;
    for (int j = 0; j < NR; j++) p ^= lvl(j, t);
    return p;
  endfunction

  logic pk1 = 0, pk2 = 0, pq1 = 0, pq2 = 0;
  int ncyc = 0;
  always @(posedge samp_clk) begin
    pk2 <= pk1;
    pk1 <= par_all($time);
    pq2 <= pq1;
    pq1 <= lvl(0, $time);
    ncyc <= rst ? 0 : ncyc + 1;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  logic [15:0] eword, pend, wd_exp;
  int ebits;

  task automatic do_reset();
    @(negedge samp_clk); #300 rst = 1'b1;
    repeat (3) @(negedge samp_clk);
    check("R4 raw_valid in reset", 32'(raw_valid), 0);
    check("R4 word_out in reset", 32'(word_out), 0);
    check("R4 word_valid in reset", 32'(word_valid), 0);
    check("R4 raw_bit in reset", 32'(raw_bit), 0);
    eword = '0; pend = '0; wd_exp = '0; ebits = 0;
    #300 rst = 1'b0;
  endtask

  task automatic run_cycles(int n);
    repeat (n) begin
      @(negedge samp_clk);
      if (ncyc < 2) begin
        check("R4 raw_valid low while filling", 32'(raw_valid), 0);
      end else begin
        check("R4 raw_valid high", 32'(raw_valid), 1);
        check("R1 R2 parity of previous edge", 32'(raw_bit), 32'(pk2));
        check("R3 single ring delay", 32'(s1_bit), 32'(pq2));
      end
      if (ncyc >= 18 && ((ncyc - 18) % 16) == 0) begin
        wd_exp = pend;
        check("R5 word_valid strobe", 32'(word_valid), 1);
      end else begin
        check("R5 word_valid idle", 32'(word_valid), 0);
      end
      check("R5 R6 word_out", 32'(word_out), 32'(wd_exp));
      if (ncyc >= 2) begin
        eword = {eword[14:0], pk2};
        ebits++;
        if (ebits % 16 == 0) pend = eword;
      end
    end
  endtask

  initial begin
    #1000 rst = 1'b1;
    #9000 rst = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      @(negedge samp_clk); #300;
      clk_sel = VECS[v][16];
      fen     = VECS[v][15:8];
      fval    = VECS[v][7:0];
      do_reset();
      run_cycles(RUN_CYC);
    end

    // R7: divided clock duty and period
    @(negedge samp_clk); #300 clk_sel = 1'b1;
    do_reset();
    begin
      longint t0, t1, t2;
      @(posedge samp_clk); t0 = $time;
      @(negedge samp_clk); t1 = $time;
      @(posedge samp_clk); t2 = $time;
      check("R7 internal high time", 32'(t1 - t0), 8000);
      check("R7 internal low time", 32'(t2 - t1), 8000);
    end

    // R8: divider restarts on reset
    begin
      longint ta, tp;
      @(negedge samp_clk); #300 rst = 1'b1;
      @(posedge aux_ring); ta = $time;
      @(posedge samp_clk); tp = $time;
      check("R8 divider restart", 32'(tp - ta), 8000);
      @(negedge samp_clk); #300 rst = 1'b0;
    end

    // R7: external select follows ref_clk
    @(negedge samp_clk); #300 clk_sel = 1'b0;
    do_reset();
    begin
      longint t0, t1;
      @(posedge samp_clk); t0 = $time;
      @(posedge samp_clk); t1 = $time;
      check("R7 external period", 32'(t1 - t0), 8000);
      check("R7 external edge on ref_clk", 32'(ref_clk), 1);
    end

    // R4 R5: reset in the middle of a word restarts packing
    fen = 8'h00;
    do_reset();
    run_cycles(25);
    do_reset();
    run_cycles(RUN_CYC);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200_000_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule